// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block moves register writes from a fast bus clock into a slow low-power domain that runs at about 32.768 kHz. On the bus side it takes a write strobe with an address and data. The address and data are held steady while a toggle request crosses into the slow clock through a chain of synchronizer flops. The slow side waits a fixed number of its own cycles and then gives a single-cycle write-enable pulse with the captured address and data to the registers outside the block. A toggle acknowledge then crosses back to the bus side. Only one write can be in flight. A write that arrives while another is still in flight is rejected and raises an error flag. It is never queued.

The block keeps an interrupt-enable register that is written directly in the fast domain. It also drives a status word of progress flags (busy, write-next, complete, error), with two external event levels at their fixed positions. The interrupt output is high whenever an enabled status flag is set. Reading status clears the complete flag. A write of 1 to the error bit at the status address clears the error flag, and that clear is itself a synchronized write.

Top module: `slow_wr_sync`

## Requirements
- R1: After reset, the status word reads 0x200 (only write-next set), the interrupt enable reads 0, the interrupt is low and no slow-side write pulse occurs.
- R2: Each accepted write to any address other than the enable or status address produces exactly one single-cycle slow-side pulse carrying the same address and data. The pulse comes SLOW_CYC slow cycles after the slow side detects the request.
- R3: Busy (status bit 10) is set in the fast cycle after an accepted write and stays set until the acknowledge returns. Write-next (bit 9) is always the inverse of busy.
- R4: When the acknowledge returns, busy clears and complete (bit 8) is set in the same cycle.
- R5: A status read strobe clears complete in the next cycle. A completion in the same cycle takes priority over the read.
- R6: A non-enable write that arrives while busy sets error (bit 7). The write is dropped, and the write already in flight is delivered unchanged.
- R7: A write to the enable address loads the enable register in the next cycle, keeping only bits 9, 8, 7, 4 and 0 (mask 0x391). It neither sets busy nor complete.
- R8: A write to the status address goes through the synchronizer but gives no slow-side pulse. If its data bit 7 is 1, error clears when that write completes. If bit 7 is 0, error is left as it was.
- R9: Status bit 4 mirrors the alarm input and bit 0 mirrors the violation input. The interrupt is high exactly when some status bit and the same enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast bus clock |
| rst_f_n | input | 1 | Fast-domain asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write address (word index) |
| wr_data | input | DW | Bus write data |
| rd_stat | input | 1 | Status read strobe; clears the complete flag |
| alarm_in | input | 1 | External alarm event level, shown at status bit 4 |
| viol_in | input | 1 | External security-violation level, shown at status bit 0 |
| stat_o | output | 11 | Status word: busy 10, write-next 9, complete 8, error 7, alarm 4, violation 0 |
| ien_o | output | 11 | Interrupt-enable register |
| irq_o | output | 1 | Interrupt, OR of status AND enable |
| clk_s | input | 1 | Slow low-power clock |
| rst_s_n | input | 1 | Slow-domain asynchronous reset, active low |
| s_we | output | 1 | Slow-side write-enable pulse |
| s_addr | output | AW | Slow-side write address |
| s_data | output | DW | Slow-side write data |

## Verification
The bench uses the default widths (AW=6, DW=32), SLOW_CYC=4 and two-stage synchronizers. It runs the slow clock at one eighth of the bus clock instead of the real ratio of about three thousand. This keeps a full round trip to about a hundred bus cycles, so many back-to-back writes, collisions during the in-flight window, and error clears through the status address all fit in a short run. A scoreboard queue holds the expected slow-side writes and checks that rejected writes and status-address writes never appear on the slow side.

// File: rtl/slow_wr_sync_pkg.sv
package slow_wr_sync_pkg;
    localparam int STAT_W   = 11;
    localparam int BIT_BUSY = 10;
    localparam int BIT_NEXT = 9;
    localparam int BIT_CMPL = 8;
    localparam int BIT_ERR  = 7;
    localparam int BIT_ALRM = 4;
    localparam int BIT_VIOL = 0;
    localparam logic [STAT_W-1:0] IEN_MASK = 11'h391;
endpackage

// File: rtl/swr_bit_sync.sv
module swr_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swr_fast_ctrl.sv
module swr_fast_ctrl
    import slow_wr_sync_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 32,
    parameter int STAT_ADDR = 5,
    parameter int IEN_ADDR  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_stat,
    input  logic              ack_sync,
    output logic              req_tgl,
    output logic [AW-1:0]     hold_addr,
    output logic [DW-1:0]     hold_data,
    output logic              busy,
    output logic              cmpl,
    output logic              err,
    output logic [STAT_W-1:0] ien
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);

    typedef struct packed {
        logic              req;
        logic              ack_seen;
        logic              busy;
        logic              cmpl;
        logic              err;
        logic              clr_pend;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic [STAT_W-1:0] ien;
    } fast_st_t;

    fast_st_t st_d, st_q;
    logic     is_ien, is_xfer, done;

    always_comb begin
        st_d    = st_q;
        is_ien  = wr_en && (wr_addr == IEN_A);
        is_xfer = wr_en && (wr_addr != IEN_A);
        done    = ack_sync != st_q.ack_seen;
        if (rd_stat) st_d.cmpl = 1'b0;
        if (done) begin
            st_d.ack_seen = ~st_q.ack_seen;
            st_d.busy     = 1'b0;
            st_d.cmpl     = 1'b1;
            st_d.clr_pend = 1'b0;
            if (st_q.clr_pend) st_d.err = 1'b0;
        end
        if (is_ien) st_d.ien = wr_data[STAT_W-1:0] & IEN_MASK;
        if (is_xfer) begin
            if (st_q.busy) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy     = 1'b1;
                st_d.req      = ~st_q.req;
                st_d.addr     = wr_addr;
                st_d.data     = wr_data;
                st_d.clr_pend = (wr_addr == STAT_A) && wr_data[BIT_ERR];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl   = st_q.req;
    assign hold_addr = st_q.addr;
    assign hold_data = st_q.data;
    assign busy      = st_q.busy;
    assign cmpl      = st_q.cmpl;
    assign err       = st_q.err;
    assign ien       = st_q.ien;
endmodule

// File: rtl/swr_slow_ctrl.sv
module swr_slow_ctrl #(
    parameter int AW        = 6,
    parameter int DW        = 32,
    parameter int STAT_ADDR = 5,
    parameter int SLOW_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_sync,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_data,
    output logic          ack_tgl,
    output logic          s_we,
    output logic [AW-1:0] s_addr,
    output logic [DW-1:0] s_data
);
    localparam int            CW     = (SLOW_CYC > 1) ? $clog2(SLOW_CYC) : 1;
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [CW-1:0] CNT_LD = CW'(SLOW_CYC - 1);

    typedef struct packed {
        logic          req_seen;
        logic          active;
        logic [CW-1:0] cnt;
        logic          ack;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (st_q.active) begin
            if (st_q.cnt == '0) begin
                st_d.active = 1'b0;
                st_d.ack    = ~st_q.ack;
                st_d.we     = st_q.addr != STAT_A;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_sync != st_q.req_seen) begin
            st_d.req_seen = ~st_q.req_seen;
            st_d.active   = 1'b1;
            st_d.cnt      = CNT_LD;
            st_d.addr     = hold_addr;
            st_d.data     = hold_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;
    assign s_we    = st_q.we;
    assign s_addr  = st_q.addr;
    assign s_data  = st_q.data;
endmodule

// File: rtl/slow_wr_sync.sv
module slow_wr_sync
    import slow_wr_sync_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 32,
    parameter int STAT_ADDR   = 5,
    parameter int IEN_ADDR    = 6,
    parameter int SLOW_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_f,
    input  logic              rst_f_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_stat,
    input  logic              alarm_in,
    input  logic              viol_in,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] ien_o,
    output logic              irq_o,
    input  logic              clk_s,
    input  logic              rst_s_n,
    output logic              s_we,
    output logic [AW-1:0]     s_addr,
    output logic [DW-1:0]     s_data
);
    logic          req_tgl, req_sync, ack_tgl, ack_sync;
    logic          busy, cmpl, err;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    swr_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_s), .rst_n(rst_s_n), .d(req_tgl), .q(req_sync)
    );
    swr_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_f), .rst_n(rst_f_n), .d(ack_tgl), .q(ack_sync)
    );

    swr_fast_ctrl #(.AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)) u_fast (
        .clk(clk_f), .rst_n(rst_f_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stat(rd_stat), .ack_sync(ack_sync),
        .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
        .busy(busy), .cmpl(cmpl), .err(err), .ien(ien_o)
    );

    swr_slow_ctrl #(.AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .SLOW_CYC(SLOW_CYC)) u_slow (
        .clk(clk_s), .rst_n(rst_s_n), .req_sync(req_sync),
        .hold_addr(hold_addr), .hold_data(hold_data), .ack_tgl(ack_tgl),
        .s_we(s_we), .s_addr(s_addr), .s_data(s_data)
    );

    always_comb begin
        stat_o           = '0;
        stat_o[BIT_BUSY] = busy;
        stat_o[BIT_NEXT] = ~busy;
        stat_o[BIT_CMPL] = cmpl;
        stat_o[BIT_ERR]  = err;
        stat_o[BIT_ALRM] = alarm_in;
        stat_o[BIT_VIOL] = viol_in;
    end

    assign irq_o = |(stat_o & ien_o);
endmodule

// File: rtl/slow_wr_sync_chk.sv
module slow_wr_sync_chk
    import slow_wr_sync_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 32,
    parameter int STAT_ADDR = 5,
    parameter int IEN_ADDR  = 6
) (
    input logic              clk_f,
    input logic              rst_f_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              rd_stat,
    input logic [STAT_W-1:0] stat_o,
    input logic [STAT_W-1:0] ien_o,
    input logic              clk_s,
    input logic              rst_s_n,
    input logic              s_we,
    input logic [AW-1:0]     s_addr
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);

    AST_BUSY_ON_WRITE: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (wr_en && wr_addr != IEN_A && !stat_o[BIT_BUSY]) |=> stat_o[BIT_BUSY]); // R3
    AST_DONE_SETS_CMPL: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        $fell(stat_o[BIT_BUSY]) |-> stat_o[BIT_CMPL]); // R4
    AST_READ_CLEARS_CMPL: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (rd_stat && !stat_o[BIT_BUSY]) |=> !stat_o[BIT_CMPL]); // R5
    AST_OVERLAP_ERR: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (wr_en && wr_addr != IEN_A && stat_o[BIT_BUSY]) |=> stat_o[BIT_ERR]); // R6
    AST_IEN_NO_CMPL: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (wr_en && wr_addr == IEN_A && !stat_o[BIT_BUSY]) |=> !$rose(stat_o[BIT_CMPL])); // R7
    AST_IEN_LOAD: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (wr_en && wr_addr == IEN_A) |=> (ien_o == ($past(wr_data[STAT_W-1:0]) & IEN_MASK))); // R7
    AST_SWE_SINGLE: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        s_we |=> !s_we); // R2
    AST_NO_STAT_FWD: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        s_we |-> (s_addr != STAT_A)); // R8
endmodule

bind slow_wr_sync slow_wr_sync_chk #(
    .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) u_chk (
    .clk_f(clk_f), .rst_f_n(rst_f_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stat(rd_stat), .stat_o(stat_o), .ien_o(ien_o),
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_we(s_we), .s_addr(s_addr)
);

// File: tb/slow_wr_sync_bench.sv
module slow_wr_sync_bench;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int STAT_ADDR = 5;
    localparam int IEN_ADDR = 6;

    logic          clk_f = 1'b0, clk_s = 1'b0;
    logic          rst_f_n = 1'b0, rst_s_n = 1'b0;
    logic          wr_en = 1'b0, rd_stat = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          alarm_in = 1'b0, viol_in = 1'b0;
    logic [10:0]   stat_o, ien_o;
    logic          irq_o, s_we;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;

    int checks = 0;
    int fails = 0;
    logic [AW+DW-1:0] exp_q[$];

    always #5 clk_f = ~clk_f;
    always #40 clk_s = ~clk_s;

    slow_wr_sync #(.AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR),
                   .SLOW_CYC(4), .SYNC_STAGES(2)) u_slow_wr_sync (
        .clk_f(clk_f), .rst_f_n(rst_f_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stat(rd_stat), .alarm_in(alarm_in), .viol_in(viol_in),
        .stat_o(stat_o), .ien_o(ien_o), .irq_o(irq_o), .clk_s(clk_s),
        .rst_s_n(rst_s_n), .s_we(s_we), .s_addr(s_addr), .s_data(s_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected slow-side writes (R2, R6, R8)
    always @(negedge clk_s) begin
        if (rst_s_n && s_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 actual=%0h expected=none", {s_addr, s_data});
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                if ({s_addr, s_data} !== e) begin
                    fails++;
                    $display("FAIL R2 actual=%0h expected=%0h", {s_addr, s_data}, e);
                end
            end
        end
    end

    // drives one write; returns at the negedge after the registering edge
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_fwd);
        @(negedge clk_f);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (expect_fwd) exp_q.push_back({a, d});
        @(negedge clk_f);
        wr_en = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk_f);
        rd_stat = 1'b1;
        @(negedge clk_f);
        rd_stat = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!stat_o[10]) break;
            @(negedge clk_f);
        end
        chk("R3 idle", stat_o[10], 1'b0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #95;
        rst_f_n = 1'b1; rst_s_n = 1'b1;
        @(negedge clk_f);
        // R1 reset state
        chk("R1 stat", stat_o, 11'h200);
        chk("R1 ien", ien_o, 11'h000);
        chk("R1 irq", irq_o, 1'b0);

        // R3/R4 basic transfer
        bus_write(6'd3, 32'hA5A5_0001, 1'b1);
        chk("R3 busy", stat_o[10], 1'b1);
        chk("R3 next", stat_o[9], 1'b0);
        wait_idle();
        chk("R4 cmpl", stat_o[8], 1'b1);
        chk("R3 next back", stat_o[9], 1'b1);

        // R5 read clears complete
        read_stat();
        chk("R5 cmpl clr", stat_o[8], 1'b0);

        // R7 enable write: masked, immediate, no busy/complete
        bus_write(6'(IEN_ADDR), 32'h0000_0FFF, 1'b0);
        chk("R7 ien", ien_o, 11'h391);
        chk("R7 busy", stat_o[10], 1'b0);
        repeat (200) @(negedge clk_f);
        chk("R7 no cmpl", stat_o[8], 1'b0);

        // R9 interrupt from complete
        bus_write(6'(IEN_ADDR), 32'h0000_0100, 1'b0);
        chk("R9 irq low", irq_o, 1'b0);
        bus_write(6'd1, 32'h1234_5678, 1'b1);
        wait_idle();
        chk("R9 irq cmpl", irq_o, 1'b1);
        read_stat();
        chk("R9 irq after read", irq_o, 1'b0);
        alarm_in = 1'b1;
        #1;
        chk("R9 alarm bit", stat_o[4], 1'b1);
        chk("R9 alarm masked", irq_o, 1'b0);
        bus_write(6'(IEN_ADDR), 32'h0000_0010, 1'b0);
        chk("R9 alarm irq", irq_o, 1'b1);
        alarm_in = 1'b0; viol_in = 1'b1;
        #1;
        chk("R9 viol bit", stat_o[0], 1'b1);
        chk("R9 viol masked", irq_o, 1'b0);
        viol_in = 1'b0;

        // R6 overlap: second write dropped, error set
        bus_write(6'd2, 32'hCAFE_0002, 1'b1);
        bus_write(6'd4, 32'hDEAD_0004, 1'b0);
        chk("R6 err", stat_o[7], 1'b1);
        chk("R6 still busy", stat_o[10], 1'b1);
        wait_idle();
        chk("R6 err held", stat_o[7], 1'b1);

        // R8 status write without bit 7 keeps error
        bus_write(6'(STAT_ADDR), 32'h0000_0000, 1'b0);
        wait_idle();
        chk("R8 err kept", stat_o[7], 1'b1);
        // R8 status write with bit 7 clears error at completion
        bus_write(6'(STAT_ADDR), 32'h0000_0080, 1'b0);
        chk("R8 err until done", stat_o[7], 1'b1);
        wait_idle();
        chk("R8 err clr", stat_o[7], 1'b0);
        chk("R8 cmpl", stat_o[8], 1'b1);

        // R2 several patterns
        for (int k = 0; k < 6; k++) begin
            bus_write(6'(k * 7 + 8), 32'h0101_0101 * (k + 1) ^ 32'hF0F0_0000, 1'b1);
            wait_idle();
        end

        repeat (100) @(negedge clk_f);
        chk("R2 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule